// File: doc/BRIEF.md
# Peripheral Board Bus Slave with Access Sequencer

This block connects a small stack processor to a board of buttons, switches, LEDs and two seven-segment display bytes. The processor side is a sequencer that takes one access request at a time: a fetch, a store, or a slow store. It drives an 8-bit shared data bus with chip-select, output-enable and write-enable strobes. Each access is stretched over a fixed number of cycles. The write strobe is raised in the first of those cycles only.

The slave side decodes the bus address. On reads it drives the bus with the button or switch state. On writes it latches the bus byte into one of four output bytes: the LED low and high bytes and the display low and high bytes. Fetched bytes are zero-extended to 16 bits and returned with a one-cycle completion pulse. The shared bus is a tristate net: each side drives it only while its enable is high.

Top module: `periph_bus_slave`

## Requirements
- R1: After reset, `leds`, `seg` and `rd_data` are zero, `bus_cs`, `bus_oe`, `bus_we` and `acc_done` are low, and `req_ready` is high.
- R2: A fetch whose address has bits [1:0] = 00 returns `buttons[7:0]` in `rd_data[7:0]`, with `rd_data[15:8]` zero.
- R3: A fetch whose address has bits [1:0] = 01 returns `buttons[14:8]` in `rd_data[6:0]`, with `rd_data[15:7]` zero.
- R4: A fetch whose address has bits [1:0] = 10 or 11 returns `switches` in `rd_data[7:0]`, with `rd_data[15:8]` zero.
- R5: A store to address 4 sets `leds[7:0]` and a store to address 5 sets `leds[15:8]`. A store to address 6 sets `seg[7:0]` and a store to address 7 sets `seg[15:8]`. A store to any other address changes neither `leds` nor `seg`.
- R6: A fetch (`req_kind` = 0) or store (`req_kind` = 1) holds `bus_cs` high for exactly 3 cycles. `acc_done` pulses in the cycle after the last of them.
- R7: A slow store (`req_kind` = 2 or 3) holds `bus_cs` high for exactly 8 cycles, then pulses `acc_done`. It writes exactly as a store does.
- R8: In a store or slow store, `bus_we` is high for exactly one cycle, the first cycle of the access, and `bus_oe` stays low throughout. In a fetch, `bus_oe` is high in every access cycle and `bus_we` never rises.
- R9: A request made while an access is in progress (`req_ready` low) is ignored. It starts no access, changes no latch, and the running access completes on its normal schedule.
- R10: The sequencer and the slave never both drive `bus_data` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start an access; taken when `req_ready` is high |
| req_kind | input | 2 | 0 fetch, 1 store, 2/3 slow store |
| req_addr | input | 4 | Bus address of the access |
| req_wdata | input | 8 | Byte to write on a store |
| req_ready | output | 1 | High when no access is in progress |
| acc_done | output | 1 | One-cycle pulse when an access completes |
| rd_data | output | 16 | Zero-extended result of the last fetch |
| bus_addr | output | 4 | Address on the peripheral bus |
| bus_cs | output | 1 | Chip-select strobe |
| bus_oe | output | 1 | Output-enable strobe (read) |
| bus_we | output | 1 | Write-enable strobe |
| bus_data | inout | 8 | Shared tristate data bus |
| buttons | input | 15 | Push-button states |
| switches | input | 8 | Slide-switch states |
| leds | output | 16 | LED output latches |
| seg | output | 16 | Seven-segment display bytes (high, low) |

## Verification
The bench issues fetches with all button bits set at address 1. A slave that failed to zero-pad would return 0xFF there instead of 0x7F. It stores to addresses 0–3 and 8–15 and compares the latches with a model, so a partial address decode would corrupt an LED or display byte. It counts the strobe cycles of every access: a write strobe held past the first cycle, or a slow store that runs short, shows up as a wrong count. It also raises a second request in the middle of an access. A sequencer that accepted it would write an unexpected byte or finish late.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
  localparam int DATA_W  = 8;
  localparam int NUM_WR  = 4;
  typedef enum logic [1:0] {
    K_FETCH = 2'd0,
    K_STORE = 2'd1,
    K_SLOW0 = 2'd2,
    K_SLOW1 = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/pbs_access_seq.sv
module pbs_access_seq
  import pbs_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int SHORT_CYC = 3,
  parameter int LONG_CYC  = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic [1:0]            req_kind,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  output logic                  req_ready,
  output logic [ADDR_W-1:0]     bus_addr,
  output logic                  bus_cs,
  output logic                  bus_oe,
  output logic                  bus_we,
  output logic                  mst_en,
  output logic [DATA_W-1:0]     mst_q,
  input  logic [DATA_W-1:0]     bus_in,
  output logic                  acc_done,
  output logic [2*DATA_W-1:0]   rd_data
);
  localparam int CNT_W = $clog2(LONG_CYC + 1) + 1;

  logic              exec_q;
  logic [1:0]        kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  limit;
  logic              is_fetch;

  assign is_fetch = (kind_q == K_FETCH);
  assign limit    = (kind_q[1]) ? CNT_W'(LONG_CYC) : CNT_W'(SHORT_CYC);

  always_ff @(posedge clk) begin
    if (rst) begin
      exec_q   <= 1'b0;
      kind_q   <= K_FETCH;
      addr_q   <= '0;
      wdata_q  <= '0;
      cnt_q    <= CNT_W'(1);
      acc_done <= 1'b0;
      rd_data  <= '0;
    end else begin
      acc_done <= 1'b0;
      if (!exec_q) begin
        cnt_q <= CNT_W'(1);
        if (req_valid) begin
          exec_q  <= 1'b1;
          kind_q  <= req_kind;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
        end
      end else if (cnt_q >= limit) begin
        exec_q   <= 1'b0;
        cnt_q    <= CNT_W'(1);
        acc_done <= 1'b1;
        if (is_fetch) rd_data <= {{DATA_W{1'b0}}, bus_in};
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign req_ready = !exec_q;
  assign bus_addr  = addr_q;
  assign bus_cs    = exec_q;
  assign bus_oe    = exec_q && is_fetch;
  assign bus_we    = exec_q && !is_fetch && (cnt_q == CNT_W'(1));
  assign mst_en    = exec_q && !is_fetch;
  assign mst_q     = wdata_q;

  a_r8_we_single: assert property (@(posedge clk) disable iff (rst)
    bus_we |=> !bus_we);
  a_r8_oe_we_excl: assert property (@(posedge clk) disable iff (rst)
    !(bus_oe && bus_we));
  a_r6_cs_min: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_cs) |=> bus_cs);
  a_r9_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    acc_done |-> $past(bus_cs));
  a_r2_zero_ext: assert property (@(posedge clk) disable iff (rst)
    acc_done |-> (rd_data[2*DATA_W-1:DATA_W] == '0));
endmodule

// File: rtl/pbs_read_mux.sv
module pbs_read_mux
  import pbs_pkg::*;
#(
  parameter int BTN_N = 15
) (
  input  logic [1:0]        sel,
  input  logic [BTN_N-1:0]  buttons,
  input  logic [DATA_W-1:0] switches,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] hi_byte;
  assign hi_byte = DATA_W'(buttons[BTN_N-1:DATA_W]);

  always_comb begin
    case (sel)
      2'b00:   q = buttons[DATA_W-1:0];
      2'b01:   q = hi_byte;
      default: q = switches;
    endcase
  end
endmodule

// File: rtl/pbs_out_latch.sv
module pbs_out_latch
  import pbs_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int WR_BASE = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_cs,
  input  logic                     bus_we,
  input  logic [DATA_W-1:0]        bus_in,
  output logic [2*DATA_W-1:0]      leds,
  output logic [2*DATA_W-1:0]      seg
);
  logic [NUM_WR-1:0][DATA_W-1:0] bytes_q;

  for (genvar i = 0; i < NUM_WR; i++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst) bytes_q[i] <= '0;
      else if (bus_cs && bus_we && bus_addr == ADDR_W'(WR_BASE + i))
        bytes_q[i] <= bus_in;
    end
  end

  assign leds = {bytes_q[1], bytes_q[0]};
  assign seg  = {bytes_q[3], bytes_q[2]};

  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    !(bus_cs && bus_we) |=> ($stable(leds) && $stable(seg)));
endmodule

// File: rtl/periph_bus_slave.sv
module periph_bus_slave
  import pbs_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int BTN_N     = 15,
  parameter int WR_BASE   = 4,
  parameter int SHORT_CYC = 3,
  parameter int LONG_CYC  = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic [1:0]             req_kind,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  output logic                   req_ready,
  output logic                   acc_done,
  output logic [2*DATA_W-1:0]    rd_data,
  output logic [ADDR_W-1:0]      bus_addr,
  output logic                   bus_cs,
  output logic                   bus_oe,
  output logic                   bus_we,
  inout  wire  [DATA_W-1:0]      bus_data,
  input  logic [BTN_N-1:0]       buttons,
  input  logic [DATA_W-1:0]      switches,
  output logic [2*DATA_W-1:0]    leds,
  output logic [2*DATA_W-1:0]    seg
);
  logic              mst_en;
  logic [DATA_W-1:0] mst_q;
  logic              slv_en;
  logic [DATA_W-1:0] slv_q;
  logic [DATA_W-1:0] bus_in;

  pbs_access_seq #(.ADDR_W(ADDR_W), .SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .bus_addr(bus_addr), .bus_cs(bus_cs), .bus_oe(bus_oe), .bus_we(bus_we),
    .mst_en(mst_en), .mst_q(mst_q), .bus_in(bus_in),
    .acc_done(acc_done), .rd_data(rd_data)
  );

  pbs_read_mux #(.BTN_N(BTN_N)) u_rmux (
    .sel(bus_addr[1:0]), .buttons(buttons), .switches(switches), .q(slv_q)
  );

  assign slv_en = bus_cs && bus_oe;

  pbs_out_latch #(.ADDR_W(ADDR_W), .WR_BASE(WR_BASE)) u_lat (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_cs(bus_cs),
    .bus_we(bus_we), .bus_in(bus_in), .leds(leds), .seg(seg)
  );

  assign bus_data = slv_en ? slv_q : (mst_en ? mst_q : {DATA_W{1'bz}});
  assign bus_in   = bus_data;

  a_r10_one_driver: assert property (@(posedge clk) disable iff (rst)
    !(slv_en && mst_en));
endmodule

// File: tb/periph_bus_slave_tb.sv
module periph_bus_slave_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'd0;
  logic [3:0]  req_addr = 4'd0;
  logic [7:0]  req_wdata = 8'd0;
  logic        req_ready, acc_done, bus_cs, bus_oe, bus_we;
  logic [15:0] rd_data, leds, seg;
  logic [3:0]  bus_addr;
  wire  [7:0]  bus_data;
  logic [14:0] buttons = '0;
  logic [7:0]  switches = '0;

  int n_tests = 0, n_fail = 0;
  logic [15:0] m_leds = '0, m_seg = '0;
  int cs_n, we_n, oe_n, lat;
  logic we_first;
  logic summary_done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  periph_bus_slave u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .acc_done(acc_done), .rd_data(rd_data), .bus_addr(bus_addr),
    .bus_cs(bus_cs), .bus_oe(bus_oe), .bus_we(bus_we), .bus_data(bus_data),
    .buttons(buttons), .switches(switches), .leds(leds), .seg(seg)
  );

  function automatic logic [15:0] exp_read(logic [3:0] a, logic [14:0] b, logic [7:0] s);
    case (a[1:0])
      2'b00:   return {8'h00, b[7:0]};
      2'b01:   return {9'h000, b[14:8]};
      default: return {8'h00, s};
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_write(logic [3:0] a, logic [7:0] d);
    case (a)
      4'd4: m_leds[7:0]  = d;
      4'd5: m_leds[15:8] = d;
      4'd6: m_seg[7:0]   = d;
      4'd7: m_seg[15:8]  = d;
      default: ;
    endcase
  endtask

  // Called at a negedge; returns at the negedge where acc_done is high.
  task automatic access(logic [1:0] k, logic [3:0] a, logic [7:0] d, bit intrude);
    req_kind = k; req_addr = a; req_wdata = d; req_valid = 1'b1;
    @(posedge clk);
    cs_n = 0; we_n = 0; oe_n = 0; lat = 0; we_first = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
      if (acc_done) break;
      if (bus_cs) cs_n++;
      if (bus_we) begin we_n++; if (lat == 0) we_first = 1'b1; end
      if (bus_oe) oe_n++;
      lat++;
      if (intrude && lat == 1) begin
        req_valid = 1'b1; req_kind = 2'd1; req_addr = 4'd4; req_wdata = ~d;
      end
    end
  endtask

  task automatic check_access(logic [1:0] k, logic [3:0] a);
    int cyc;
    cyc = k[1] ? 8 : 3;
    chk(k[1] ? "R7 latency" : "R6 latency", lat, cyc);
    chk(k[1] ? "R7 cs cycles" : "R6 cs cycles", cs_n, cyc);
    if (k == 2'd0) begin
      chk("R8 fetch oe cycles", oe_n, cyc);
      chk("R8 fetch no we", we_n, 0);
    end else begin
      chk("R8 we count", we_n, 1);
      chk("R8 we in first cycle", we_first, 1);
      chk("R8 store oe low", oe_n, 0);
      chk("R5 leds", leds, m_leds);
      chk("R5 seg", seg, m_seg);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    if (!summary_done) $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int seed_sink;
    seed_sink = $urandom(32'd2024);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 leds", leds, 0);
    chk("R1 seg", seg, 0);
    chk("R1 rd_data", rd_data, 0);
    chk("R1 strobes", {bus_cs, bus_oe, bus_we, acc_done}, 0);
    chk("R1 ready", req_ready, 1);

    // R3: all buttons high at address 1 -> 0x7F
    buttons = 15'h7FFF; switches = 8'hA5;
    access(2'd0, 4'd1, 8'h00, 0);
    chk("R3 hi byte pad", rd_data, 16'h007F);
    check_access(2'd0, 4'd1);
    access(2'd0, 4'd0, 8'h00, 0);
    chk("R2 lo byte", rd_data, 16'h00FF);
    access(2'd0, 4'd2, 8'h00, 0);
    chk("R4 switches addr2", rd_data, 16'h00A5);
    access(2'd0, 4'd3, 8'h00, 0);
    chk("R4 switches addr3", rd_data, 16'h00A5);

    // R5: each write address, then out-of-range stores
    for (int a = 4; a < 8; a++) begin
      access(2'd1, 4'(a), 8'(8'h11 * a), 0);
      model_write(4'(a), 8'(8'h11 * a));
      check_access(2'd1, 4'(a));
    end
    for (int a = 0; a < 16; a++) begin
      if (a >= 4 && a < 8) continue;
      access(2'd1, 4'(a), 8'hEE, 0);
      chk("R5 other addr leds", leds, m_leds);
      chk("R5 other addr seg", seg, m_seg);
    end

    // R7: slow store
    access(2'd2, 4'd6, 8'h3C, 0);
    model_write(4'd6, 8'h3C);
    check_access(2'd2, 4'd6);
    access(2'd3, 4'd5, 8'hC3, 0);
    model_write(4'd5, 8'hC3);
    check_access(2'd3, 4'd5);

    // R9: intruding request during an access
    access(2'd1, 4'd7, 8'h5A, 1);
    model_write(4'd7, 8'h5A);
    chk("R9 latency unchanged", lat, 3);
    chk("R9 leds untouched", leds, m_leds);
    chk("R9 seg", seg, m_seg);
    chk("R9 ready after", req_ready, 1);
    @(negedge clk);
    chk("R9 no extra access", bus_cs, 0);
    access(2'd2, 4'd4, 8'h99, 1);
    model_write(4'd4, 8'h99);
    chk("R9 slow latency unchanged", lat, 8);
    chk("R9 slow leds", leds, m_leds);

    // Random mix
    for (int n = 0; n < 80; n++) begin
      logic [1:0] k;
      logic [3:0] a;
      logic [7:0] d;
      k = 2'($urandom_range(0, 3));
      a = 4'($urandom_range(0, 15));
      d = 8'($urandom);
      buttons = 15'($urandom);
      switches = 8'($urandom);
      access(k, a, d, 0);
      if (k == 2'd0) begin
        chk(a[1:0] == 2'b00 ? "R2 rand read" : (a[1:0] == 2'b01 ? "R3 rand read" : "R4 rand read"),
            rd_data, exp_read(a, buttons, switches));
      end else begin
        model_write(a, d);
      end
      check_access(k, a);
    end

    summary_done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule